// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block sends 32-bit avionics data words onto a two-wire, three-level, return-to-zero line pair. It has two logic outputs, `legHi` and `legLo`, and an external line driver turns them into the bipolar bus levels. A CPU writes words through a single-cycle write strobe into a small word FIFO, and the transmitter drains that FIFO one word at a time.

Before a word is sent, the block replaces its top bit with odd parity. It sends the 8-bit label first, most significant bit first, and then the rest of the word least significant bit first. Each bit period drives its level for the first half and returns to null for the second half. Every word is followed by a null gap of at least four bit times.

The bit period comes from two selects: the system clock frequency and the line rate. Both are sampled once, at the start of each word. While no word is in flight, the line rests at null.

Top module: `a429_word_tx`

## Requirements
- R1: Each word goes out as exactly 32 bits, in this order: `wrData[7]` down to `wrData[0]` (the label, most significant bit first), then `wrData[8]` up to `wrData[31]`.
- R2: A one bit pulses `legHi`, a zero bit pulses `legLo`, and null drives both low. The two legs are never high together.
- R3: Every bit holds its active level for exactly H clock cycles and then stays null for exactly H cycles. H is the half-bit count defined in R7.
- R4: After the last bit of a word, the line stays null for at least the rest of that bit plus four full bit times before the next word starts.
- R5: Bit 32, the parity bit (`wrData[31]` position), is sent as odd parity over `wrData[30:0]`. The value written into bit 31 is ignored.
- R6: Out of reset, and whenever no word is being sent, `legHi` and `legLo` are both 0. After reset, `fifoEmpty` is 1, `fifoFull` is 0 and `wrDropped` is 0.
- R7: H = f / (2 × rate). The clock frequency f is selected by `clkSel`: 0 = 1 MHz, 1 = 10 MHz, 2 = 16 MHz, 3 = 20 MHz. The rate is selected by `rateSel`: 0 = 100 kbps, 1 = 50 kbps, 2 and 3 = 12.5 kbps. Both selects are sampled at the start of each word, so a change during a word has no effect on that word.
- R8: The FIFO holds `FIFO_DEPTH` words and sends them in write order. `fifoFull` and `fifoEmpty` report its occupancy.
- R9: A write while `fifoFull` is 1 is dropped and is never sent. `wrDropped` is 1 for exactly the one cycle after that write edge.
- R10: When the block is idle and the FIFO is empty, the first bit of a written word appears on the legs two clock edges after the write edge. At the edge before that, the legs are still null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Word write strobe |
| wrData | input | 32 | Word to queue |
| clkSel | input | 2 | System clock frequency select |
| rateSel | input | 2 | Line bit-rate select |
| legHi | output | 1 | Leg A drive, high for a one bit |
| legLo | output | 1 | Leg B drive, high for a zero bit |
| fifoFull | output | 1 | FIFO holds `FIFO_DEPTH` words |
| fifoEmpty | output | 1 | FIFO holds no word |
| wrDropped | output | 1 | One-cycle pulse after a dropped write |

## Verification
On an idle block, a leg rises two edges after the write edge. After that, every pulse lasts H cycles and every bit period lasts 2H cycles. `wrDropped` and the FIFO flags change one edge after the write that caused them.

The bench drives inputs and samples outputs on the falling edge. A scoreboard monitor rebuilds each word from the rising pulses and counts the cycles of every active run, every null run and every inter-word gap, so the check does not depend on when a word was queued. The two-edge latency, the flags and the dropped-write pulse are checked at fixed falling edges counted from the write.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  localparam int WORD_BITS  = 32;
  localparam int LABEL_BITS = 8;
  localparam int HALF_W     = 12;

  typedef struct packed {
    logic load;    // pop the FIFO head into the shift register
    logic shift;   // advance to the next serial bit
    logic active;  // drive the current bit this cycle
  } txStrobe_t;

  // Half-bit length in clock cycles for the selected clock and rate.
  function automatic logic [HALF_W-1:0] halfClocks(input logic [1:0] clkSel,
                                                   input logic [1:0] rateSel);
    logic [HALF_W-1:0] base;
    case (clkSel)
      2'd0:    base = HALF_W'(5);
      2'd1:    base = HALF_W'(50);
      2'd2:    base = HALF_W'(80);
      default: base = HALF_W'(100);
    endcase
    case (rateSel)
      2'd0:    return base;
      2'd1:    return base << 1;
      default: return base << 3;
    endcase
  endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         empty,
  output logic         dropped
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doWr, doRd;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dropped <= 1'b0;
    end else begin
      dropped <= wrEn && full;
      if (doWr) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8: the controller pops only a non-empty FIFO
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !empty);

  // R9: a write into a full FIFO raises the drop pulse next cycle
  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full) |=> dropped);

endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEmpty,
  input  logic [1:0] clkSel,
  input  logic [1:0] rateSel,
  output logic      popEn,
  output txStrobe_t strobe
);

  localparam int MAX_IDX   = (WORD_BITS > GAP_BITS) ? WORD_BITS : GAP_BITS;
  localparam int BIT_IDX_W = $clog2(MAX_IDX);
  localparam int GAPC_W    = BIT_IDX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} txState_t;

  txState_t             state;
  logic [HALF_W-1:0]    halfLim, cnt;
  logic                 phase;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 halfEnd, bitEnd;
  logic [GAPC_W-1:0]    gapSeen;
  logic                 sentAny;

  assign halfEnd = (cnt == halfLim - 1'b1);
  assign bitEnd  = halfEnd && phase;

  always_comb begin
    popEn         = (state == S_IDLE) && !fifoEmpty;
    strobe.load   = popEn;
    strobe.shift  = (state == S_SEND) && bitEnd;
    strobe.active = (state == S_SEND) && !phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfLim <= HALF_W'(5);
      cnt     <= '0;
      phase   <= 1'b0;
      bitIdx  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (popEn) begin
            halfLim <= halfClocks(clkSel, rateSel);
            cnt     <= '0;
            phase   <= 1'b0;
            bitIdx  <= '0;
            state   <= S_SEND;
          end
        end
        default: begin
          if (halfEnd) begin
            cnt   <= '0;
            phase <= ~phase;
            if (phase) begin
              if (state == S_SEND) begin
                if (bitIdx == BIT_IDX_W'(WORD_BITS - 1)) begin
                  bitIdx <= '0;
                  state  <= S_GAP;
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                end
              end else begin
                if (bitIdx == BIT_IDX_W'(GAP_BITS - 1)) begin
                  bitIdx <= '0;
                  state  <= S_IDLE;
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                end
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // Gap-length bookkeeping that only the assertion below reads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapSeen <= '0;
      sentAny <= 1'b0;
    end else if (strobe.load) begin
      gapSeen <= '0;
      sentAny <= 1'b1;
    end else if (state == S_GAP && bitEnd) begin
      gapSeen <= gapSeen + 1'b1;
    end
  end

  // R4: a new word starts only after the full null gap
  p_gap_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && sentAny) |-> (gapSeen >= GAPC_W'(GAP_BITS)));

endmodule

// File: rtl/a429_tx_datapath.sv
module a429_tx_datapath
  import a429_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobe_t            strobe,
  input  logic [WORD_BITS-1:0] headWord,
  output logic                 legHi,
  output logic                 legLo
);

  logic [WORD_BITS-1:0] shiftReg;

  // Put odd parity in the top bit, then arrange the bits in line order.
  function automatic logic [WORD_BITS-1:0] lineOrder(input logic [WORD_BITS-1:0] w);
    logic [WORD_BITS-1:0] p;
    logic [WORD_BITS-1:0] s;
    p = {~^w[WORD_BITS-2:0], w[WORD_BITS-2:0]};
    for (int i = 0; i < WORD_BITS; i++) begin
      if (i < LABEL_BITS) s[i] = p[LABEL_BITS-1-i];
      else                s[i] = p[i];
    end
    return s;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      legHi    <= 1'b0;
      legLo    <= 1'b0;
    end else begin
      if (strobe.load)       shiftReg <= lineOrder(headWord);
      else if (strobe.shift) shiftReg <= shiftReg >> 1;
      legHi <= strobe.active &&  shiftReg[0];
      legLo <= strobe.active && !shiftReg[0];
    end
  end

  // R2: the two legs are never driven together
  p_legs_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(legHi && legLo));

  // R5: a freshly loaded word always carries an odd number of ones
  p_parity_odd_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (^shiftReg));

endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic [1:0]  clkSel,
  input  logic [1:0]  rateSel,
  output logic        legHi,
  output logic        legLo,
  output logic        fifoFull,
  output logic        fifoEmpty,
  output logic        wrDropped
);

  logic                 popEn;
  logic [WORD_BITS-1:0] headWord;
  txStrobe_t            strobe;

  a429_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_BITS)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(popEn), .rdData(headWord),
    .full(fifoFull), .empty(fifoEmpty), .dropped(wrDropped)
  );

  a429_tx_ctrl #(.GAP_BITS(GAP_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty),
    .clkSel(clkSel), .rateSel(rateSel),
    .popEn(popEn), .strobe(strobe)
  );

  a429_tx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headWord(headWord),
    .legHi(legHi), .legLo(legLo)
  );

endmodule

// File: tb/a429_word_tx_tb.sv
`timescale 1ns/1ps
module a429_word_tx_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0] clkSel = 2'd0;
  logic [1:0] rateSel = 2'd0;
  logic legHi, legLo, fifoFull, fifoEmpty, wrDropped;

  int nChecks = 0;
  int nFails = 0;
  int expHalf = 5;
  logic [31:0] expQ[$];

  always #2.5 clk = ~clk;

  a429_word_tx u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .clkSel(clkSel), .rateSel(rateSel), .legHi(legHi), .legLo(legLo),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .wrDropped(wrDropped)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Word in the order it should appear on the line, parity applied.
  function automatic logic [31:0] expSerial(input logic [31:0] w);
    logic [31:0] p;
    logic [31:0] s;
    p = {~^w[30:0], w[30:0]};
    for (int i = 0; i < 32; i++) s[i] = (i < 8) ? p[7 - i] : p[i];
    return s;
  endfunction

  function automatic int halfFor(input logic [1:0] c, input logic [1:0] r);
    longint fHz;
    longint bps;
    case (c)
      2'd0: fHz = 1000000;
      2'd1: fHz = 10000000;
      2'd2: fHz = 16000000;
      default: fHz = 20000000;
    endcase
    case (r)
      2'd0: bps = 100000;
      2'd1: bps = 50000;
      default: bps = 12500;
    endcase
    return int'(fHz / (2 * bps));
  endfunction

  // Driver: one write, recorded in the scoreboard when it should survive.
  task automatic writeWord(input logic [31:0] w, input bit kept);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    if (kept) expQ.push_back(w);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (10 * expHalf + 4) @(negedge clk);
    check(!legHi && !legLo, "R6", "legs null when idle", {legHi, legLo}, 0);
    check(fifoEmpty, "R8", "fifoEmpty after drain", fifoEmpty, 1);
  endtask

  task automatic setRate(input logic [1:0] c, input logic [1:0] r);
    clkSel = c;
    rateSel = r;
    expHalf = halfFor(c, r);
  endtask

  // Monitor: rebuild words from the legs and compare them with the scoreboard.
  int cyc = 0;
  always @(posedge clk) cyc++;

  initial begin
    logic [31:0] got;
    logic [31:0] want;
    int pw;
    int nl;
    int lastEnd;
    int lastHalf;
    bit seen;
    bit pwOk;
    bit perOk;
    seen = 0;
    lastEnd = 0;
    lastHalf = 0;
    forever begin
      @(negedge clk);
      if (legHi || legLo) begin
        if (seen)
          check((cyc - lastEnd) >= 9 * lastHalf, "R4", "null gap between words",
                cyc - lastEnd, 9 * lastHalf);
        pwOk = 1;
        perOk = 1;
        got = '0;
        for (int b = 0; b < 32; b++) begin
          if (b > 0) begin
            nl = 0;
            while (!(legHi || legLo) && nl <= 4 * expHalf) begin
              nl++;
              @(negedge clk);
            end
            if (nl != expHalf) perOk = 0;
          end
          got[b] = legHi;
          if (legHi && legLo) pwOk = 0;
          pw = 0;
          while (legHi || legLo) begin
            pw++;
            @(negedge clk);
          end
          if (pw != expHalf) pwOk = 0;
        end
        lastEnd = cyc;
        lastHalf = expHalf;
        seen = 1;
        check(pwOk, "R3", "active half length", pwOk, 1);
        check(perOk, "R7", "null half length for selected rate", perOk, 1);
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected word on line", got, 0);
        end else begin
          want = expQ.pop_front();
          check(got == expSerial(want), "R1/R5", "serial word", got, expSerial(want));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!legHi && !legLo, "R6", "legs in reset", {legHi, legLo}, 0);
    check(fifoEmpty && !fifoFull && !wrDropped, "R6", "flags in reset",
          {fifoEmpty, fifoFull, wrDropped}, 3'b100);
    rstN = 1'b1;
    setRate(2'd0, 2'd0);
    repeat (3) @(negedge clk);

    // R10: latency from the write edge to the first pulse
    writeWord(32'hA5A5_00C3, 1);
    @(negedge clk);
    check(!legHi && !legLo, "R10", "legs null one edge after write", {legHi, legLo}, 0);
    @(negedge clk);
    check(legHi || legLo, "R10", "first pulse two edges after write", {legHi, legLo}, 1);
    drain();

    // Back-to-back words with varied parity and bit patterns (R1, R2, R5, R8)
    writeWord(32'h0000_0000, 1);
    writeWord(32'hFFFF_FFFF, 1);
    writeWord(32'h8000_0001, 1);
    writeWord(32'h1234_5678, 1);
    drain();

    // R9: fill the FIFO while the first word is on the line, then overflow it
    writeWord(32'h0000_0011, 1);
    writeWord(32'h0000_0022, 1);
    writeWord(32'h0000_0033, 1);
    writeWord(32'h0000_0044, 1);
    writeWord(32'h0000_0055, 1);
    check(fifoFull, "R8", "fifoFull after depth writes", fifoFull, 1);
    check(!wrDropped, "R9", "no drop before overflow", wrDropped, 0);
    writeWord(32'hDEAD_BEEF, 0);
    check(wrDropped, "R9", "drop pulse after overflow write", wrDropped, 1);
    @(negedge clk);
    check(!wrDropped, "R9", "drop pulse lasts one cycle", wrDropped, 0);
    drain();

    // R7: each clock and rate selection
    setRate(2'd0, 2'd1); writeWord(32'h0F0F_0F0F, 1); drain();
    setRate(2'd0, 2'd2); writeWord(32'h7000_00FE, 1); drain();
    setRate(2'd1, 2'd1); writeWord(32'h3C3C_3C3C, 1); drain();
    setRate(2'd2, 2'd0); writeWord(32'h0001_8000, 1); drain();
    setRate(2'd3, 2'd0); writeWord(32'hCAFE_0101, 1); drain();
    setRate(2'd3, 2'd3); writeWord(32'h5555_AAAA, 1); drain();

    // R7: a rate change during a word does not affect that word
    setRate(2'd0, 2'd0);
    writeWord(32'h2468_ACE0, 1);
    repeat (20) @(negedge clk);
    rateSel = 2'd2;
    drain();
    rateSel = 2'd0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule